// File: doc/BRIEF.md
# Four-Die Byte-Wide Asynchronous Memory Front End

This block is a synthesizable behavioural model of a byte-wide non-volatile memory. It answers like a plain asynchronous SRAM, but inside it holds four separate die that share one set of pins. A host either selects a single die with one of four active-low die strobes, or drops a shared "whole array" strobe. In that mode the two top address bits choose the die, in a fixed non-binary order. The remaining address bits pick the byte inside the chosen die. Each die is a small array whose depth is a parameter, so the model stays cheap to simulate. Only the low address bits that the depth needs are used.

Reads are combinational from the pins. The data bus is split into an input byte, an output byte and an output-drive flag. Writes happen while a die is selected and the write strobe is low. They are modelled on a sampling clock. The byte and location seen in the last sampled cycle of that overlap are stored on the clock edge after the overlap ends. The overlap can end when the write strobe rises, when the die strobe rises, or when the selection moves to another die. A low-supply inhibit input and a sleep/reset input can each cancel a write. Strobe patterns that select more than one die are flagged, and nothing happens during them.

Top module: `mdm_front`

## Requirements
- R1: With the whole-array strobe low and all four die strobes high, address bits [22:21] pick the die: 00 gives die 0, 01 gives die 1, 10 gives die 3, 11 gives die 2.
- R2: With the whole-array strobe high and exactly one die strobe low (bit n of the strobe vector selects die n), that die is used, and address bits [22:21] have no effect.
- R3: Address bits [20:0] select the byte within the chosen die. Only the low log2(DEPTH) bits are decoded, so locations that differ only above them alias.
- R4: While sleep/reset is high, all other inputs are ignored: the output-drive flag is low, the illegal flag is low and no write is stored.
- R5: With sleep/reset low and no die selected, the output-drive flag is low.
- R6: A selected die with the write strobe high and the read strobe low drives the stored byte with the output-drive flag high. With the read strobe high, the flag stays low.
- R7: While the write strobe is low, the output-drive flag is low whatever the read strobe does.
- R8: A write stores the data byte and location present in the last sampled cycle of the overlap. It is stored on the clock edge where the overlap is seen to have ended, whether the write strobe or the die strobe ends it.
- R9: If the low-supply inhibit is high in the last sampled cycle of the overlap, the write is discarded.
- R10: Two or more die strobes low at once, or the whole-array strobe low together with any die strobe, raise the illegal flag. In that state nothing is driven and nothing is written.
- R11: If sleep/reset rises before a write overlap has ended, that write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for write capture and commit |
| rst_n | input | 1 | Active-low reset of the write-capture state |
| sleep_rst | input | 1 | High puts the device in sleep/reset; all other inputs ignored |
| lowv_inhibit | input | 1 | High marks low supply; suppresses writes |
| die_en_n | input | 4 | Active-low per-die strobes, bit n for die n |
| all_en_n | input | 1 | Active-low whole-array strobe (die from address [22:21]) |
| wr_n | input | 1 | Active-low write strobe |
| rd_oe_n | input | 1 | Active-low output (read) strobe |
| addr | input | 23 | Byte address |
| dq_i | input | 8 | Data byte from the bus |
| dq_o | output | 8 | Data byte to the bus |
| dq_oe | output | 1 | High while the block drives the bus |
| illegal | output | 1 | High while the strobe pattern selects more than one die |

## Verification
The bound checker watches several rules on every cycle. The bus is never driven during sleep, with the write strobe low, or in an illegal strobe state. Driving always implies a read strobe. The whole-array address map picks the die listed in R1. A store fires only on the edge after an overlap, never while sleeping, and never when the inhibit was high in the last overlap cycle. Only the bench scenarios can show that the stored bytes are the right ones. It sweeps every location of every die, writing through one selection mode and reading through the other. It checks aliasing, that the last byte of an overlap wins, that writes ended by a die strobe commit, and that cancelled, inhibited and illegal writes leave memory unchanged.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  localparam int DIES   = 4;
  localparam int DIE_W  = 2;
  localparam int ADDR_W = 23;
  localparam int DATA_W = 8;

  typedef logic [DIE_W-1:0] die_t;

  typedef enum logic [1:0] {
    SEL_IDLE = 2'd0,
    SEL_ONE  = 2'd1,
    SEL_BAD  = 2'd2
  } sel_kind_e;

  // Whole-array map: top address pair -> die. The upper bit gives the
  // die's upper bit; the lower die bit is the xor of the pair.
  function automatic die_t die_from_top(input logic [1:0] top);
    die_from_top = {top[1], top[1] ^ top[0]};
  endfunction

  // Number of active (low) die strobes.
  function automatic int unsigned count_low(input logic [DIES-1:0] en_n);
    int unsigned n;
    n = 0;
    for (int i = 0; i < DIES; i++) n += (en_n[i] == 1'b0) ? 1 : 0;
    count_low = n;
  endfunction

  // Index of the lowest active die strobe.
  function automatic die_t first_low(input logic [DIES-1:0] en_n);
    die_t d;
    d = '0;
    for (int i = DIES - 1; i >= 0; i--) if (en_n[i] == 1'b0) d = die_t'(i);
    first_low = d;
  endfunction

endpackage

// File: rtl/mdm_die_select.sv
module mdm_die_select
  import mdm_pkg::*;
(
  input  logic            sleep_rst,
  input  logic [DIES-1:0] die_en_n,
  input  logic            all_en_n,
  input  logic [1:0]      top_bits,
  output logic            sel_valid,
  output die_t            sel_die,
  output logic            sel_illegal
);

  sel_kind_e   kind;
  int unsigned n_low;

  always_comb begin
    n_low   = count_low(die_en_n);
    kind    = SEL_IDLE;
    sel_die = '0;
    if (!all_en_n) begin
      if (n_low != 0) kind = SEL_BAD;
      else begin
        kind    = SEL_ONE;
        sel_die = die_from_top(top_bits);
      end
    end else if (n_low == 1) begin
      kind    = SEL_ONE;
      sel_die = first_low(die_en_n);
    end else if (n_low > 1) begin
      kind = SEL_BAD;
    end
    if (sleep_rst) kind = SEL_IDLE;
  end

  assign sel_valid   = (kind == SEL_ONE);
  assign sel_illegal = (kind == SEL_BAD);

endmodule

// File: rtl/mdm_write_ctl.sv
module mdm_write_ctl
  import mdm_pkg::*;
#(
  parameter int LOC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_rst,
  input  logic              lowv_inhibit,
  input  logic              sel_valid,
  input  die_t              sel_die,
  input  logic [LOC_W-1:0]  sel_loc,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] din,
  output logic              overlap,
  output logic              commit,
  output die_t              cm_die,
  output logic [LOC_W-1:0]  cm_loc,
  output logic [DATA_W-1:0] cm_data
);

  logic ov_q;
  logic inh_q;
  logic ended;

  // A write overlap: a legal die selected with the write strobe low.
  assign overlap = sel_valid && !wr_n;

  // The overlap ends when it drops or moves to another die.
  assign ended  = ov_q && (!overlap || (sel_die != cm_die));
  assign commit = ended && !sleep_rst && !inh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q    <= 1'b0;
      inh_q   <= 1'b0;
      cm_die  <= '0;
      cm_loc  <= '0;
      cm_data <= '0;
    end else begin
      ov_q <= overlap;
      if (overlap) begin
        inh_q   <= lowv_inhibit;
        cm_die  <= sel_die;
        cm_loc  <= sel_loc;
        cm_data <= din;
      end
    end
  end

endmodule

// File: rtl/mdm_die_array.sv
module mdm_die_array
  import mdm_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LOC_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  die_t              wr_die,
  input  logic [LOC_W-1:0]  wr_loc,
  input  logic [DATA_W-1:0] wr_data,
  input  die_t              rd_die,
  input  logic [LOC_W-1:0]  rd_loc,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] die_q [DIES];

  for (genvar g = 0; g < DIES; g++) begin : g_die
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_die == die_t'(g))) cells[wr_loc] <= wr_data;
    end

    assign die_q[g] = cells[rd_loc];
  end

  assign rd_data = die_q[rd_die];

endmodule

// File: rtl/mdm_front.sv
module mdm_front
  import mdm_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LOC_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_rst,
  input  logic              lowv_inhibit,
  input  logic [3:0]        die_en_n,
  input  logic              all_en_n,
  input  logic              wr_n,
  input  logic              rd_oe_n,
  input  logic [22:0]       addr,
  input  logic [7:0]        dq_i,
  output logic [7:0]        dq_o,
  output logic              dq_oe,
  output logic              illegal
);

  logic              sel_valid;
  die_t              sel_die;
  logic              sel_illegal;
  logic [LOC_W-1:0]  sel_loc;
  logic              wr_overlap;
  logic              wr_commit;
  die_t              cm_die;
  logic [LOC_W-1:0]  cm_loc;
  logic [DATA_W-1:0] cm_data;
  logic [DATA_W-1:0] rd_data;
  logic              rd_active;
  logic              unused_addr;

  assign sel_loc     = addr[LOC_W-1:0];
  assign unused_addr = ^addr[20:LOC_W];

  mdm_die_select u_sel (
    .sleep_rst   (sleep_rst),
    .die_en_n    (die_en_n),
    .all_en_n    (all_en_n),
    .top_bits    (addr[22:21]),
    .sel_valid   (sel_valid),
    .sel_die     (sel_die),
    .sel_illegal (sel_illegal)
  );

  mdm_write_ctl #(.LOC_W(LOC_W)) u_wr (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_rst    (sleep_rst),
    .lowv_inhibit (lowv_inhibit),
    .sel_valid    (sel_valid),
    .sel_die      (sel_die),
    .sel_loc      (sel_loc),
    .wr_n         (wr_n),
    .din          (dq_i),
    .overlap      (wr_overlap),
    .commit       (wr_commit),
    .cm_die       (cm_die),
    .cm_loc       (cm_loc),
    .cm_data      (cm_data)
  );

  mdm_die_array #(.DEPTH(DEPTH)) u_arr (
    .clk     (clk),
    .wr_en   (wr_commit),
    .wr_die  (cm_die),
    .wr_loc  (cm_loc),
    .wr_data (cm_data),
    .rd_die  (sel_die),
    .rd_loc  (sel_loc),
    .rd_data (rd_data)
  );

  assign rd_active = sel_valid && wr_n && !rd_oe_n;
  assign dq_oe     = rd_active;
  assign dq_o      = rd_active ? rd_data : '0;
  assign illegal   = sel_illegal;

endmodule

// File: rtl/mdm_front_chk.sv
module mdm_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sleep_rst,
  input logic        lowv_inhibit,
  input logic [3:0]  die_en_n,
  input logic        all_en_n,
  input logic        wr_n,
  input logic        rd_oe_n,
  input logic [22:0] addr,
  input logic        dq_oe,
  input logic        illegal,
  input logic        sel_valid,
  input logic [1:0]  sel_die,
  input logic        overlap,
  input logic        commit
);

  a_r1_top_map: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_rst && !all_en_n && die_en_n == 4'hF) |->
      (sel_valid && sel_die == (addr[22] ? (addr[21] ? 2'd2 : 2'd3)
                                         : (addr[21] ? 2'd1 : 2'd0))));

  a_r4_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_rst |-> (!dq_oe && !illegal && !commit));

  a_r6_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!rd_oe_n && wr_n));

  a_r7_no_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !dq_oe);

  a_r8_commit_after_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(overlap));

  a_r9_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !$past(lowv_inhibit));

  a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!dq_oe && !sel_valid && !overlap));

endmodule

bind mdm_front mdm_front_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_rst    (sleep_rst),
  .lowv_inhibit (lowv_inhibit),
  .die_en_n     (die_en_n),
  .all_en_n     (all_en_n),
  .wr_n         (wr_n),
  .rd_oe_n      (rd_oe_n),
  .addr         (addr),
  .dq_oe        (dq_oe),
  .illegal      (illegal),
  .sel_valid    (sel_valid),
  .sel_die      (sel_die),
  .overlap      (wr_overlap),
  .commit       (wr_commit)
);

// File: tb/mdm_front_test.sv
module mdm_front_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_rst = 1'b0;
  logic        lowv_inhibit = 1'b0;
  logic [3:0]  die_en_n = 4'hF;
  logic        all_en_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        rd_oe_n = 1'b1;
  logic [22:0] addr = '0;
  logic [7:0]  dq_i = '0;
  logic [7:0]  dq_o;
  logic        dq_oe;
  logic        illegal;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [7:0] model [4][DEPTH];

  mdm_front #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_rst(sleep_rst), .lowv_inhibit(lowv_inhibit),
    .die_en_n(die_en_n), .all_en_n(all_en_n), .wr_n(wr_n), .rd_oe_n(rd_oe_n),
    .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .illegal(illegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Whole-array top bits for a die, per R1 table.
  function automatic logic [1:0] top_for(input int d);
    case (d)
      0: top_for = 2'b00;
      1: top_for = 2'b01;
      2: top_for = 2'b11;
      default: top_for = 2'b10;
    endcase
  endfunction

  function automatic logic [7:0] pat(input int d, input int l);
    pat = 8'((d * 37 + l * 5 + 3) % 256);
  endfunction

  task automatic idle();
    die_en_n = 4'hF; all_en_n = 1'b1; wr_n = 1'b1; rd_oe_n = 1'b1;
    sleep_rst = 1'b0; lowv_inhibit = 1'b0;
  endtask

  // mode 0: per-die strobe with free top bits; mode 1: whole-array strobe.
  task automatic sel(input int mode, input int d, input int a, input logic [1:0] top);
    if (mode == 0) begin
      all_en_n = 1'b1; die_en_n = ~(4'b0001 << d);
      addr = {top, 21'(a)};
    end else begin
      all_en_n = 1'b0; die_en_n = 4'hF;
      addr = {top_for(d), 21'(a)};
    end
  endtask

  task automatic wr(input int mode, input int d, input int a, input logic [1:0] top,
                    input logic [7:0] v);
    @(negedge clk); sel(mode, d, a, top); dq_i = v; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); idle();
  endtask

  task automatic rd(input string req, input int mode, input int d, input int a,
                    input logic [1:0] top, input logic [7:0] exp);
    @(negedge clk); sel(mode, d, a, top); rd_oe_n = 1'b0;
    #1;
    chk(req, {23'd0, dq_oe, dq_o}, {23'd0, 1'b1, exp});
    idle();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("reset dq_oe", dq_oe, 0);
    chk("reset illegal", illegal, 0);

    // R1 write every location of every die through the whole-array map,
    // R2 read back through per-die strobes with varying top bits, R3 locations.
    for (int d = 0; d < 4; d++)
      for (int l = 0; l < DEPTH; l++) begin
        wr(1, d, l, 2'b00, pat(d, l));
        model[d][l] = pat(d, l);
      end
    for (int d = 0; d < 4; d++)
      for (int l = 0; l < DEPTH; l++)
        rd("R1 R2 R3 sweep", 0, d, l, 2'(l), model[d][l]);

    // R3 aliasing above the decoded bits
    wr(0, 1, 7 + DEPTH, 2'b10, 8'hA5); model[1][7] = 8'hA5;
    rd("R3 alias", 1, 1, 7, 2'b00, 8'hA5);

    // R5 nothing selected
    @(negedge clk); idle(); rd_oe_n = 1'b0; #1;
    chk("R5 idle no drive", dq_oe, 0);
    // R6 read strobe high
    @(negedge clk); sel(0, 2, 3, 2'b00); rd_oe_n = 1'b1; #1;
    chk("R6 oe high no drive", dq_oe, 0);
    idle();

    // R7 outputs off during write with read strobe low; R8 last byte wins
    @(negedge clk); sel(0, 3, 9, 2'b01); rd_oe_n = 1'b0; wr_n = 1'b0; dq_i = 8'h11; #1;
    chk("R7 write no drive", dq_oe, 0);
    @(negedge clk); dq_i = 8'h22;
    @(negedge clk); dq_i = 8'h33;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); idle();
    model[3][9] = 8'h33;
    rd("R8 last overlap byte", 1, 3, 9, 2'b00, 8'h33);

    // R8 overlap ended by the die strobe rising
    @(negedge clk); sel(0, 0, 12, 2'b00); dq_i = 8'h5C; wr_n = 1'b0;
    @(negedge clk); die_en_n = 4'hF;
    @(negedge clk); idle();
    model[0][12] = 8'h5C;
    rd("R8 die strobe ends write", 0, 0, 12, 2'b11, 8'h5C);

    // R9 inhibit in last overlap cycle
    @(negedge clk); sel(1, 2, 20, 2'b00); dq_i = 8'hEE; wr_n = 1'b0; lowv_inhibit = 1'b1;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); idle();
    rd("R9 inhibited write", 0, 2, 20, 2'b00, model[2][20]);

    // R4 sleep: no drive, no flag, no write
    @(negedge clk); sleep_rst = 1'b1; die_en_n = 4'b0011; rd_oe_n = 1'b0; #1;
    chk("R4 sleep no drive", dq_oe, 0);
    chk("R4 sleep no illegal", illegal, 0);
    @(negedge clk); die_en_n = 4'b1110; addr = 23'd4; dq_i = 8'h77; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); idle();
    rd("R4 sleep write ignored", 0, 0, 4, 2'b00, model[0][4]);

    // R11 sleep rising before overlap ends
    @(negedge clk); sel(0, 1, 30, 2'b00); dq_i = 8'h99; wr_n = 1'b0;
    @(negedge clk); sleep_rst = 1'b1;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); idle();
    rd("R11 aborted write", 0, 1, 30, 2'b00, model[1][30]);

    // R10 two die strobes low
    @(negedge clk); die_en_n = 4'b1010; addr = 23'd5; rd_oe_n = 1'b0; #1;
    chk("R10 two strobes flag", illegal, 1);
    chk("R10 two strobes no drive", dq_oe, 0);
    rd_oe_n = 1'b1; dq_i = 8'h42; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); idle();
    rd("R10 no write die0", 0, 0, 5, 2'b00, model[0][5]);
    rd("R10 no write die2", 0, 2, 5, 2'b00, model[2][5]);
    // R10 whole-array strobe with a die strobe
    @(negedge clk); all_en_n = 1'b0; die_en_n = 4'b0111; addr = 23'd6; rd_oe_n = 1'b0; #1;
    chk("R10 mixed flag", illegal, 1);
    chk("R10 mixed no drive", dq_oe, 0);
    idle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule